// File: doc/BRIEF.md
# Dual-Mode Pattern Generator and Signature Register

This block is a built-in self-test register in which one bank of flip-flops does two jobs. In generate mode it runs as an autonomous linear feedback shift register. It shifts toward the most significant bit and feeds the XOR of a fixed tap set back into bit 0, so its contents serve as a pseudorandom stimulus word. In signature mode the same shift and feedback still happen, and a parallel response word from the circuit under test is XORed into every stage on each clock. The register then compacts a stream of responses into one signature.

A test session is started with a programmable length. A small session controller has three states. `SES_IDLE` is the state after reset. `SES_RUN` lets the register step once per clock. `SES_DONE` freezes the register and raises a done flag. The transitions are as follows. IDLE to RUN happens on start with a nonzero length. IDLE to DONE happens on start with a zero length. RUN to DONE happens on the last counted step. DONE to RUN or DONE happens on a new start, with the same rule as from IDLE. While the block is done, the register is compared with a golden signature and the match flag reports the result. A nonzero seed can be loaded at any time and takes priority over stepping. A zero seed would lock the generator at zero, so the block ignores it.

Top module: `bist_sigreg`

## Requirements
- R1: After reset the register holds RESET_SEED (default 1), done_o is 0 and match_o is 0.
- R2: When seed_load_i is 1 and seed_i is nonzero, the register takes seed_i at that clock edge in any state. The load takes priority over a step, and that edge does not count toward the session length.
- R3: A seed_load_i with seed_i equal to zero is ignored. The register does not load it and behaves as if no load had been requested.
- R4: A step with mode_i = 0 (generate) produces next = {q[W-2:0], fb}, where fb is the XOR of the bits of q selected by TAPS. The default is W = 8 with TAPS = 8'hB8.
- R5: With W = 4 and TAPS = 4'hC, seeded with 4'b1000, the register visits 15 distinct nonzero values and is back at 4'b1000 after 15 steps.
- R6: A step with mode_i = 1 (signature) produces next = {q[W-2:0], fb} XOR resp_i.
- R7: mode_i is sampled at each stepping edge, so a change of mode applies from the very next clock edge and may change from cycle to cycle.
- R8: A start_i in IDLE or DONE begins a session of len_i steps. The register steps on exactly len_i edges after the start edge, and done_o rises after the last of them. A zero len_i goes to DONE at the start edge with no step. A start_i during RUN is ignored.
- R9: In IDLE and DONE the register holds its value unless a nonzero seed is loaded.
- R10: match_o is 1 only when done_o is 1 and state_o equals golden_i. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 0 = pattern generation, 1 = signature compaction |
| seed_load_i | input | 1 | Load seed_i into the register (ignored if seed is zero) |
| seed_i | input | WIDTH | Seed value |
| start_i | input | 1 | Begin a session of len_i steps |
| len_i | input | CNT_W | Number of steps in the session |
| resp_i | input | WIDTH | Parallel response word from the circuit under test |
| golden_i | input | WIDTH | Known-good signature for comparison |
| state_o | output | WIDTH | Current pattern or signature |
| done_o | output | 1 | Session finished |
| match_o | output | 1 | Done and signature equals golden_i |

## Verification
The assertions assume that seed_i is only meaningful while seed_load_i is high. They also assume that start_i and len_i are held steady around the clock edge that samples them. The stimulus drives every input on the falling edge and samples on the falling edge, so each input is stable across the edge that uses it. Random sessions only ever load nonzero seeds, and zero seeds are applied only in the directed case that checks they are rejected. Random response words are applied in both modes, including sessions where the mode flips from cycle to cycle.

// File: rtl/bist_pkg.sv
package bist_pkg;
    typedef enum logic [1:0] {
        SES_IDLE = 2'd0,
        SES_RUN  = 2'd1,
        SES_DONE = 2'd2
    } ses_state_e;
endpackage

// File: rtl/bist_shift_core.sv
module bist_shift_core #(
    parameter int              WIDTH      = 8,
    parameter logic [WIDTH-1:0] TAPS       = 8'hB8,
    parameter logic [WIDTH-1:0] RESET_SEED = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic             sig_mode,
    input  logic             load_ok,
    input  logic [WIDTH-1:0] seed,
    input  logic [WIDTH-1:0] resp,
    output logic [WIDTH-1:0] q
);
    logic             fb;
    logic [WIDTH-1:0] nxt;

    assign fb = ^(q & TAPS);

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            assign nxt[i] = fb ^ (sig_mode & resp[i]);
        end else begin : g_body
            assign nxt[i] = q[i-1] ^ (sig_mode & resp[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RESET_SEED;
        end else if (load_ok) begin
            q <= seed;
        end else if (step_en) begin
            q <= nxt;
        end
    end

    assert_seed_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_ok |=> (q == $past(seed)));
    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_ok && !step_en) |=> $stable(q));
    assert_gen_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load_ok && !sig_mode && (q != '0)) |=> (q != '0));
endmodule

// File: rtl/bist_session_fsm.sv
module bist_session_fsm
    import bist_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    input  logic             pause,
    output logic             step_en,
    output logic             done
);
    ses_state_e       state, state_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SES_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            SES_IDLE, SES_DONE: begin
                if (start) begin
                    cnt_nxt   = len;
                    state_nxt = (len == '0) ? SES_DONE : SES_RUN;
                end
            end
            SES_RUN: begin
                if (!pause) begin
                    cnt_nxt = cnt - 1'b1;
                    if (cnt == 1) state_nxt = SES_DONE;
                end
            end
            default: state_nxt = SES_IDLE;
        endcase
    end

    always_comb begin
        step_en = (state == SES_RUN) && !pause;
        done    = (state == SES_DONE);
    end

    assert_run_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SES_RUN) |-> (cnt != '0));
    assert_zero_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != SES_RUN) && start && (len == '0)) |=> done);
    assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);
endmodule

// File: rtl/bist_sig_compare.sv
module bist_sig_compare #(
    parameter int WIDTH = 8
) (
    input  logic             done,
    input  logic [WIDTH-1:0] sig,
    input  logic [WIDTH-1:0] golden,
    output logic             match
);
    always_comb match = done && (sig == golden);
endmodule

// File: rtl/bist_sigreg.sv
module bist_sigreg #(
    parameter int               WIDTH      = 8,
    parameter logic [WIDTH-1:0] TAPS       = 8'hB8,
    parameter logic [WIDTH-1:0] RESET_SEED = 1,
    parameter int               CNT_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_i,
    input  logic             seed_load_i,
    input  logic [WIDTH-1:0] seed_i,
    input  logic             start_i,
    input  logic [CNT_W-1:0] len_i,
    input  logic [WIDTH-1:0] resp_i,
    input  logic [WIDTH-1:0] golden_i,
    output logic [WIDTH-1:0] state_o,
    output logic             done_o,
    output logic             match_o
);
    logic load_ok;
    logic step_en;

    assign load_ok = seed_load_i && (seed_i != '0);

    bist_session_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start_i), .len(len_i),
        .pause(load_ok), .step_en(step_en), .done(done_o)
    );

    bist_shift_core #(.WIDTH(WIDTH), .TAPS(TAPS), .RESET_SEED(RESET_SEED)) u_core (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .sig_mode(mode_i),
        .load_ok(load_ok), .seed(seed_i), .resp(resp_i), .q(state_o)
    );

    bist_sig_compare #(.WIDTH(WIDTH)) u_cmp (
        .done(done_o), .sig(state_o), .golden(golden_i), .match(match_o)
    );

    assert_zero_seed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_load_i && (seed_i == '0) && !done_o && !step_en) |=> $stable(state_o));
    assert_match_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> done_o);
endmodule

// File: tb/bist_sigreg_tb.sv
module bist_sigreg_tb_top;
    logic clk = 0;
    logic rst_n = 0;
    always #2 clk = ~clk;

    logic        mode_i = 0, seed_load_i = 0, start_i = 0;
    logic [7:0]  seed_i = 0, resp_i = 0, golden_i = 0;
    logic [15:0] len_i = 0;
    logic [7:0]  state_o;
    logic        done_o, match_o;

    logic        seed_load4 = 0, start4 = 0;
    logic [3:0]  seed4 = 0, q4;
    logic [15:0] len4 = 0;
    logic        done4, match4;

    int checks = 0, fails = 0;
    logic [7:0] exp_q;

    bist_sigreg dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .seed_load_i(seed_load_i),
        .seed_i(seed_i), .start_i(start_i), .len_i(len_i), .resp_i(resp_i),
        .golden_i(golden_i), .state_o(state_o), .done_o(done_o), .match_o(match_o)
    );

    bist_sigreg #(.WIDTH(4), .TAPS(4'hC), .RESET_SEED(4'h1), .CNT_W(16)) dut4_i (
        .clk(clk), .rst_n(rst_n), .mode_i(1'b0), .seed_load_i(seed_load4),
        .seed_i(seed4), .start_i(start4), .len_i(len4), .resp_i(4'h0),
        .golden_i(4'h0), .state_o(q4), .done_o(done4), .match_o(match4)
    );

    function automatic logic [7:0] step8(logic [7:0] q, logic [7:0] r, logic sig);
        logic fb;
        fb = ^(q & 8'hB8);
        return {q[6:0], fb} ^ (sig ? r : 8'h00);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_session(int len, int kind, bit flip);
        logic m;
        @(negedge clk);
        start_i = 1; len_i = 16'(len);
        @(posedge clk);
        @(negedge clk);
        start_i = 0;
        for (int c = 0; c < len; c++) begin
            m = (kind == 2) ? 1'($urandom_range(0, 1)) : 1'(kind);
            mode_i = m;
            resp_i = 8'($urandom);
            exp_q = step8(exp_q, resp_i, m);
            if (c == len - 1) check("R8 done before last step", {31'd0, done_o}, 0);
            @(posedge clk);
            @(negedge clk);
        end
        golden_i = flip ? (exp_q ^ 8'h10) : exp_q;
        #0.5;
        check("R4/R6/R7 signature", {24'd0, state_o}, {24'd0, exp_q});
        check("R8 done", {31'd0, done_o}, 1);
        check("R10 match", {31'd0, match_o}, {31'd0, !flip});
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] seen;
        logic [7:0]  hold;
        void'($urandom(32'd2024));
        exp_q = 8'h01;
        #9 rst_n = 1;
        @(negedge clk);
        check("R1 reset state", {24'd0, state_o}, 1);
        check("R1 reset done", {31'd0, done_o}, 0);
        check("R1 reset match", {31'd0, match_o}, 0);

        // R5: 4-bit instance period
        seed_load4 = 1; seed4 = 4'b1000;
        @(posedge clk); @(negedge clk);
        seed_load4 = 0; start4 = 1; len4 = 15;
        @(posedge clk); @(negedge clk);
        start4 = 0;
        seen = 16'h0001;
        for (int k = 0; k < 15; k++) begin
            @(posedge clk); @(negedge clk);
            if (k < 14) begin
                check("R5 distinct nonzero", {31'd0, seen[q4]}, 0);
                seen[q4] = 1'b1;
            end
        end
        check("R5 returns to seed", {28'd0, q4}, 32'h8);
        check("R5 done", {31'd0, done4}, 1);
        check("R5 all 15 visited", {16'd0, seen | 16'h0100}, 32'hFFFF);

        // R3: zero seed ignored in idle
        seed_load_i = 1; seed_i = 8'h00;
        @(posedge clk); @(negedge clk);
        seed_load_i = 0;
        check("R3 zero seed ignored", {24'd0, state_o}, {24'd0, exp_q});

        // R2: nonzero seed load
        seed_load_i = 1; seed_i = 8'h5A;
        @(posedge clk); @(negedge clk);
        seed_load_i = 0; exp_q = 8'h5A;
        check("R2 seed loaded", {24'd0, state_o}, 32'h5A);
        // R9: hold in idle
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 idle hold", {24'd0, state_o}, 32'h5A);

        // R8: zero-length session
        start_i = 1; len_i = 0;
        @(posedge clk); @(negedge clk);
        start_i = 0;
        check("R8 zero length done", {31'd0, done_o}, 1);
        check("R8 zero length no step", {24'd0, state_o}, 32'h5A);

        // R2: seed load during run pauses and overrides
        start_i = 1; len_i = 5; mode_i = 0;
        @(posedge clk); @(negedge clk);
        start_i = 0;
        repeat (2) begin
            exp_q = step8(exp_q, 8'h00, 1'b0);
            @(posedge clk); @(negedge clk);
        end
        golden_i = state_o;
        #0.5;
        check("R10 no match while running", {31'd0, match_o}, 0);
        seed_load_i = 1; seed_i = 8'hC3; start_i = 1; len_i = 1;
        @(posedge clk); @(negedge clk);
        seed_load_i = 0; start_i = 0; exp_q = 8'hC3;
        check("R2 load during run", {24'd0, state_o}, 32'hC3);
        repeat (3) begin
            check("R8 still running", {31'd0, done_o}, 0);
            exp_q = step8(exp_q, 8'h00, 1'b0);
            @(posedge clk); @(negedge clk);
        end
        check("R2/R8 paused count", {31'd0, done_o}, 1);
        check("R4 generate steps", {24'd0, state_o}, {24'd0, exp_q});

        // random sessions
        for (int s = 0; s < 24; s++) begin
            if ($urandom_range(0, 1) == 1) begin
                @(negedge clk);
                seed_i = 8'($urandom_range(1, 255));
                seed_load_i = 1;
                @(posedge clk); @(negedge clk);
                seed_load_i = 0; exp_q = seed_i;
            end
            run_session(int'($urandom_range(1, 40)), s % 3, (s % 4) == 3);
        end

        // R9: hold in done
        hold = state_o;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 done hold", {24'd0, state_o}, {24'd0, hold});

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule